// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupt Detection

This block is one bank of general-purpose pins behind a single-cycle register port. Each pin has an output latch and a direction bit that together drive the pad. Pad levels come back through a two-flop synchronizer. Reading the pin value always returns that synchronized pad level, even on a pin configured as an output. A separate read-only register returns the output latch, so the last value written reads back at once.

Every synchronized input feeds its own event detector. A three-bit mode code per pin, spread across three mode registers, selects the condition to watch: the falling edge, the rising edge, both edges, low level or high level. Detected events set sticky status bits. Software clears a status bit by writing 1 to it. A per-pin enable register decides which status bits reach the single combined interrupt line. A reset-tolerance register stores one bit per pin and reads back what was written.

Top module: `gpio_bank`

## Requirements
- R1: The direction register (address 2) holds one bit per pin, with 1 for output and 0 for input. `pad_oe` equals that register, and reading address 2 returns it.
- R2: A write to address 0 loads the output latch, and `pad_out` equals the latch. Reading address 1 returns the latch in the cycle right after the write. Address 1 is read-only, so a write to it has no effect.
- R3: Reading address 0 returns the pad level after exactly two clock edges, whether or not the pin is an output.
- R4: Each pin's mode is the code {m2,m1,m0}, taken from address 6 (m2), address 5 (m1) and address 4 (m0).
  - When m1 is 1, the pin detects a level: m0=1 means high and m0=0 means low.
  - When m1 is 0 and m2 is 1, the pin detects both edges.
  - When m1 and m2 are both 0, m0=1 selects the rising edge and m0=0 selects the falling edge.
  - Detection compares the newest synchronized sample with the one before it.
- R5: The status register (address 7) is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a detection and a clear hit the same bit in the same cycle, the detection wins.
- R6: `irq` is high exactly when some pin has both its status bit and its enable bit set. The enable register is at address 3.
- R7: A level-mode status bit sets again in the cycle after a clear if the level is still present.
- R8: The reset-tolerance register (address 8) is readable and writable, one bit per pin.
- R9: After reset every register reads 0, so all pins are inputs with interrupts disabled. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data, combinational from the address |
| pad_in | input | NPINS | Pad levels, asynchronous |
| pad_out | output | NPINS | Output latch to pads |
| pad_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted previous-sample register would produce false edges or miss real ones. That shows in the status read three edges after a pad change. A status bit that is cleared wrongly, or sets without a reason, shows on the status read and on `irq` in the cycle that follows. The bench gives each of the 32 pins one of the eight mode codes in turn. It walks the pads through full-swing and alternating patterns and compares every status bit with an arithmetic model after each step. A wrong decode of any mode therefore shows on at least one pin within a few cycles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_PIN   = 4'd0,
    RA_LATCH = 4'd1,
    RA_DIR   = 4'd2,
    RA_IEN   = 4'd3,
    RA_MODE0 = 4'd4,
    RA_MODE1 = 4'd5,
    RA_MODE2 = 4'd6,
    RA_STAT  = 4'd7,
    RA_KEEP  = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stg_d[s] = async_in;
      end else begin : g_next
        always_comb stg_d[s] = stg_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] mode0,
  input  logic [W-1:0] mode1,
  input  logic [W-1:0] mode2,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp;
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      logic rise, fall;
      always_comb begin
        rise = smp[i] & ~prev_q[i];
        fall = ~smp[i] & prev_q[i];
        if (mode1[i])      hit[i] = mode0[i] ? smp[i] : ~smp[i];
        else if (mode2[i]) hit[i] = rise | fall;
        else               hit[i] = mode0[i] ? rise : fall;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  localparam int SYNC_STAGES = 2;

  logic             srst_n;
  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] hit;
  reg_addr_e        addr_e;

  logic [NPINS-1:0] latch_q, dir_q, ien_q, m0_q, m1_q, m2_q, stat_q, keep_q;
  logic [NPINS-1:0] stat_d;
  logic             latch_en, dir_en, ien_en, m0_en, m1_en, m2_en, keep_en;
  logic [NPINS-1:0] clr_mask;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .async_in(pad_in), .sync_out(pin_s)
  );

  gpio_irq_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst_n(srst_n), .smp(pin_s),
    .mode0(m0_q), .mode1(m1_q), .mode2(m2_q), .hit(hit)
  );

  always_comb addr_e = reg_addr_e'(reg_addr);

  // next-state logic
  always_comb begin
    latch_en = reg_we && (addr_e == RA_PIN);
    dir_en   = reg_we && (addr_e == RA_DIR);
    ien_en   = reg_we && (addr_e == RA_IEN);
    m0_en    = reg_we && (addr_e == RA_MODE0);
    m1_en    = reg_we && (addr_e == RA_MODE1);
    m2_en    = reg_we && (addr_e == RA_MODE2);
    keep_en  = reg_we && (addr_e == RA_KEEP);
    clr_mask = (reg_we && (addr_e == RA_STAT)) ? reg_wdata : '0;
    stat_d   = (stat_q & ~clr_mask) | hit;
  end

  // register process
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      m0_q    <= '0;
      m1_q    <= '0;
      m2_q    <= '0;
      stat_q  <= '0;
      keep_q  <= '0;
    end else begin
      if (latch_en) latch_q <= reg_wdata;
      if (dir_en)   dir_q   <= reg_wdata;
      if (ien_en)   ien_q   <= reg_wdata;
      if (m0_en)    m0_q    <= reg_wdata;
      if (m1_en)    m1_q    <= reg_wdata;
      if (m2_en)    m2_q    <= reg_wdata;
      if (keep_en)  keep_q  <= reg_wdata;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    case (addr_e)
      RA_PIN:   reg_rdata = pin_s;
      RA_LATCH: reg_rdata = latch_q;
      RA_DIR:   reg_rdata = dir_q;
      RA_IEN:   reg_rdata = ien_q;
      RA_MODE0: reg_rdata = m0_q;
      RA_MODE1: reg_rdata = m1_q;
      RA_MODE2: reg_rdata = m2_q;
      RA_STAT:  reg_rdata = stat_q;
      RA_KEEP:  reg_rdata = keep_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;
  assign irq     = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      stat,
  input logic [W-1:0]      ien,
  input logic [W-1:0]      keep,
  input logic              irq
);
  // R1
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == RA_DIR) |=> $stable(pad_oe));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == RA_PIN) |=> $stable(pad_out));

  // R5
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == RA_STAT) |=> (($past(stat) & ~stat) == '0));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  // R8
  keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == RA_KEEP) |=> $stable(keep));
endmodule

bind gpio_bank gpio_bank_chk #(.W(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
  .pad_out(pad_out), .pad_oe(pad_oe), .stat(stat_q), .ien(ien_q),
  .keep(keep_q), .irq(irq)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [3:0]    reg_addr;
  logic [N-1:0]  reg_wdata, reg_rdata, pad_in, pad_out, pad_oe;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  gpio_bank #(.NPINS(N)) i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] a, output logic [N-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // expected detection for one pin with mode code c, levels before/after
  function automatic bit fires(input logic [2:0] c, input bit o, input bit n);
    bit rise = n & ~o;
    bit fall = ~n & o;
    if (c[1])      return c[0] ? (o | n) : (~o | ~n);
    else if (c[2]) return rise | fall;
    else           return c[0] ? rise : fall;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d, e, m0, m1, m2, pat_prev, snap;
    logic [N-1:0] pats [5];
    pats[0] = '0; pats[1] = '1; pats[2] = 32'h5555_5555;
    pats[3] = 32'hAAAA_AAAA; pats[4] = '0;

    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    for (int a = 0; a < 16; a++) begin
      rd_now(4'(a), d);
      chk("R9 reset read", d, '0);
    end
    chk("R9 pad_oe", pad_oe, '0);
    chk("R9 irq", {31'd0, irq}, '0);

    // R1 direction
    wr(4'd2, 32'hF0F0_1234);
    rd_now(4'd2, d);
    chk("R1 dir read", d, 32'hF0F0_1234);
    chk("R1 pad_oe", pad_oe, 32'hF0F0_1234);

    // R2 latch
    wr(4'd0, 32'hDEAD_BEEF);
    rd_now(4'd1, d);
    chk("R2 latch readback", d, 32'hDEAD_BEEF);
    chk("R2 pad_out", pad_out, 32'hDEAD_BEEF);
    wr(4'd1, 32'h1111_1111);
    rd_now(4'd1, d);
    chk("R2 latch read-only", d, 32'hDEAD_BEEF);

    // R3 two-stage sync, pad differs from latch
    @(negedge clk); pad_in = 32'h0BAD_F00D;
    @(negedge clk); rd_now(4'd0, d);
    chk("R3 after one edge", d, '0);
    @(negedge clk); rd_now(4'd0, d);
    chk("R3 after two edges", d, 32'h0BAD_F00D);
    @(negedge clk); pad_in = '0;
    repeat (4) @(negedge clk);

    // R4 / R7 sweep: pin k gets mode code k%8
    m0 = '0; m1 = '0; m2 = '0;
    for (int k = 0; k < N; k++) begin
      m0[k] = k[0]; m1[k] = k[1]; m2[k] = k[2];
    end
    wr(4'd4, m0); wr(4'd5, m1); wr(4'd6, m2);
    pat_prev = '0;
    for (int s = 0; s < 5; s++) begin
      wr(4'd7, '1);
      @(negedge clk); pad_in = pats[s];
      repeat (5) @(negedge clk);
      for (int k = 0; k < N; k++)
        e[k] = fires({m2[k], m1[k], m0[k]}, pat_prev[k], pats[s][k]);
      rd_now(4'd7, d);
      chk("R4 R7 mode sweep status", d, e);
      pat_prev = pats[s];
    end

    // drive all high; edge-rise/both and level pins get set
    @(negedge clk); pad_in = '1;
    repeat (5) @(negedge clk);
    rd_now(4'd7, snap);
    // R5 writing zeros changes nothing
    wr(4'd7, '0);
    rd_now(4'd7, d);
    chk("R5 zero write no effect", d, snap);
    // R5 clear pin1 (rising edge mode) only
    wr(4'd7, 32'h0000_0002);
    rd_now(4'd7, d);
    chk("R5 single bit clear", d, snap & ~32'h2);

    // R6 irq gating
    wr(4'd3, '0);
    chk("R6 irq no enable", {31'd0, irq}, '0);
    wr(4'd3, 32'h0000_0002);
    chk("R6 irq enabled pin clear", {31'd0, irq}, '0);
    wr(4'd3, 32'h0000_0008);
    chk("R6 irq enabled pin set", {31'd0, irq}, 32'd1);
    rd_now(4'd3, d);
    chk("R6 enable readback", d, 32'h8);

    // R7 level-high pin3 re-asserts after clear
    wr(4'd7, 32'h0000_0008);
    rd_now(4'd7, d);
    chk("R7 level re-assert", d & 32'h8, 32'h8);
    @(negedge clk); pad_in = '0;
    repeat (5) @(negedge clk);
    wr(4'd7, 32'h0000_0008);
    @(negedge clk); rd_now(4'd7, d);
    chk("R7 level gone stays clear", d & 32'h8, '0);
    chk("R6 irq drops", {31'd0, irq}, '0);
    wr(4'd3, '0);

    // R8 keep register
    wr(4'd8, 32'hA5A5_0F0F);
    rd_now(4'd8, d);
    chk("R8 keep readback", d, 32'hA5A5_0F0F);
    wr(4'd8, 32'h5A5A_F0F0);
    rd_now(4'd8, d);
    chk("R8 keep rewrite", d, 32'h5A5A_F0F0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule